// File: doc/BRIEF.md
# I2C SCL Wait-State Controller

This block owns the pull-down of the SCL open-drain pad for an I2C master or slave. It merges the transfer clock from the local clock generator with three clock-stretching sources. The first holds SCL low after the eighth pulse of a byte, so that software has time to prepare an acknowledge. The second is an unconditional force-low. The third holds SCL after the ninth pulse, so that software can inspect the received acknowledge; it takes effect only in delayed-clock mode.

The pad level is read back through a synchroniser. That synchronised copy is used to detect pulse falling edges. It also stalls the local clock generator whenever the local clock has been released but the wire is still held low, either by this block or by another device on the bus. The generator's high period therefore starts only once the wire is really high. Data shifting and acknowledge logic sit outside this block; it only receives the current pulse index from them.

Top module: `scl_wait_ctrl`

## Requirements
- R1: After synchronous reset, `scl_pull` is 0 (pad released) and `gen_stall` is 0.
- R2: One cycle after `gen_scl` is sampled low, `scl_pull` is 1. One cycle after `gen_scl` is sampled high with no hold source active, `scl_pull` is 0.
- R3: While `force_low` is 1, `scl_pull` is 1 from the next cycle on, whatever the level of `gen_scl`.
- R4: With `hold8_en` at 1, a falling edge of the synchronised SCL while `bit_idx` equals 8 latches a hold. `scl_pull` then stays 1 after `gen_scl` returns high.
- R5: When `hold8_en` goes to 0, the eighth-pulse hold is dropped and `scl_pull` falls to 0 within two cycles, provided `gen_scl` is high and no other source is active.
- R6: With `delayed_clk` at 1 and `hold9_en` at 1, a falling edge of the synchronised SCL while `bit_idx` equals 9 latches a hold that keeps `scl_pull` at 1. Clearing `hold9_en` releases it within two cycles.
- R7: When `delayed_clk` is 0, `hold9_en` has no effect: a ninth-pulse falling edge does not hold SCL.
- R8: `gen_stall` is 1 while `gen_scl` is high and the synchronised SCL is low, whether another device or this block's own hold is pulling the wire. It returns to 0 once the wire reads high again.
- R9: The pad level reaches the stall logic through a two-flop synchroniser. A change of `scl_in` sampled at edge e shows up in `gen_stall` at edge e+2, and not earlier.
- R10: A falling edge while `bit_idx` is any value other than 8 or 9 sets no hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_scl | input | 1 | Transfer clock level from the local clock generator |
| scl_in | input | 1 | Raw level read from the SCL pad |
| bit_idx | input | CNT_W | Index (1 to 9) of the SCL pulse in progress |
| hold8_en | input | 1 | Enable a hold after the eighth pulse; 0 releases it |
| force_low | input | 1 | Hold SCL low unconditionally |
| hold9_en | input | 1 | Enable a hold after the ninth pulse (delayed-clock mode only) |
| delayed_clk | input | 1 | Delayed-clock mode select |
| scl_pull | output | 1 | Pad pull-down enable, 1 drives SCL low |
| gen_stall | output | 1 | Freeze the generator's high-period counter |

## Verification
A hold latch stuck at 1 shows up as `scl_pull` staying at 1 a few cycles after `gen_scl` rises. A latch that never sets shows up as the pad released on that same rise. A wrong pulse-index compare or a missing mode gate is caught in the same way, after the scenario's falling edge. Synchroniser faults move the moment `gen_stall` changes, so the bench samples stall latency at exact edges. The bench also models the wired-AND bus from `scl_pull` and an external pull-down, so every edge the block detects comes from its own pad behaviour.

// File: rtl/scl_wait_pkg.sv
package scl_wait_pkg;
  localparam int unsigned SCLW_CNT_W  = 4;
  localparam int unsigned SCLW_IDX_A  = 8;
  localparam int unsigned SCLW_IDX_B  = 9;
  localparam int unsigned SCLW_STAGES = 2;
endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_d,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES-1:0] chain;
  logic              line_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain     <= '1;
      line_prev <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], pad_d};
      line_prev <= chain[STAGES-1];
    end
  end

  assign line_s    = chain[STAGES-1];
  assign line_fall = line_prev & ~chain[STAGES-1];
endmodule

// File: rtl/scl_hold_latch.sv
module scl_hold_latch #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IDX   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             line_fall,
  input  logic [CNT_W-1:0] bit_idx,
  output logic             held
);
  localparam logic [CNT_W-1:0] IDX_V = CNT_W'(IDX);

  always_ff @(posedge clk) begin
    if (rst)                                  held <= 1'b0;
    else if (!arm)                            held <= 1'b0;
    else if (line_fall && bit_idx == IDX_V)   held <= 1'b1;
  end

  // R5 R7
  hold_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !held);
  // R4 R6 R10
  hold_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!held && !(line_fall && bit_idx == IDX_V)) |=> !held);
endmodule

// File: rtl/scl_pad_drive.sv
module scl_pad_drive (
  input  logic clk,
  input  logic rst,
  input  logic gen_scl,
  input  logic force_low,
  input  logic hold_any,
  input  logic line_s,
  output logic scl_pull,
  output logic gen_stall
);
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pull  <= 1'b0;
      gen_stall <= 1'b0;
    end else begin
      scl_pull  <= force_low | hold_any | ~gen_scl;
      gen_stall <= gen_scl & ~line_s;
    end
  end

  // R3
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    force_low |=> scl_pull);
  // R2
  gen_low_chk: assert property (@(posedge clk) disable iff (rst)
    !gen_scl |=> scl_pull);
  // R2
  release_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_scl && !force_low && !hold_any) |=> !scl_pull);
  // R8
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (gen_scl && !line_s) |=> gen_stall);
endmodule

// File: rtl/scl_wait_ctrl.sv
module scl_wait_ctrl
  import scl_wait_pkg::*;
#(
  parameter int unsigned CNT_W  = SCLW_CNT_W,
  parameter int unsigned IDX_A  = SCLW_IDX_A,
  parameter int unsigned IDX_B  = SCLW_IDX_B,
  parameter int unsigned STAGES = SCLW_STAGES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_scl,
  input  logic             scl_in,
  input  logic [CNT_W-1:0] bit_idx,
  input  logic             hold8_en,
  input  logic             force_low,
  input  logic             hold9_en,
  input  logic             delayed_clk,
  output logic             scl_pull,
  output logic             gen_stall
);
  logic line_s, line_fall;
  logic held_a, held_b;
  logic arm_b;

  assign arm_b = hold9_en & delayed_clk;

  scl_line_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .pad_d(scl_in),
    .line_s(line_s), .line_fall(line_fall)
  );

  scl_hold_latch #(.CNT_W(CNT_W), .IDX(IDX_A)) u_hold_a (
    .clk(clk), .rst(rst), .arm(hold8_en), .line_fall(line_fall),
    .bit_idx(bit_idx), .held(held_a)
  );

  scl_hold_latch #(.CNT_W(CNT_W), .IDX(IDX_B)) u_hold_b (
    .clk(clk), .rst(rst), .arm(arm_b), .line_fall(line_fall),
    .bit_idx(bit_idx), .held(held_b)
  );

  scl_pad_drive u_drive (
    .clk(clk), .rst(rst), .gen_scl(gen_scl), .force_low(force_low),
    .hold_any(held_a | held_b), .line_s(line_s),
    .scl_pull(scl_pull), .gen_stall(gen_stall)
  );

  // R7
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!delayed_clk && !held_b) |=> !held_b);
endmodule

// File: tb/sim_scl_wait_ctrl.sv
module sim_scl_wait_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gen_scl = 1'b1;
  logic       ext_low = 1'b0;
  logic [3:0] bit_idx = 4'd1;
  logic       hold8_en = 1'b0, force_low = 1'b0, hold9_en = 1'b0, delayed_clk = 1'b0;
  logic       scl_pull, gen_stall, scl_in;
  int         runs = 0, fails = 0;

  always #10 clk = ~clk;

  assign scl_in = ~scl_pull & ~ext_low;

  scl_wait_ctrl u0 (
    .clk(clk), .rst(rst), .gen_scl(gen_scl), .scl_in(scl_in),
    .bit_idx(bit_idx), .hold8_en(hold8_en), .force_low(force_low),
    .hold9_en(hold9_en), .delayed_clk(delayed_clk),
    .scl_pull(scl_pull), .gen_stall(gen_stall)
  );

  task automatic check(input string req, input logic act, input logic exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_fall(input logic [3:0] idx);
    bit_idx = idx;
    gen_scl = 1'b1;
    cyc(6);
    gen_scl = 1'b0;
    cyc(6);
    gen_scl = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(3);
    check("R1 pull", scl_pull, 1'b0);
    check("R1 stall", gen_stall, 1'b0);
    rst = 1'b0;
    cyc(4);
  endtask

  task automatic t_gen_clock;
    gen_scl = 1'b0;
    cyc(1);
    check("R2 low", scl_pull, 1'b1);
    gen_scl = 1'b1;
    cyc(1);
    check("R2 high", scl_pull, 1'b0);
    cyc(4);
  endtask

  task automatic t_force;
    force_low = 1'b1;
    cyc(1);
    check("R3 force", scl_pull, 1'b1);
    gen_scl = 1'b0; cyc(3); gen_scl = 1'b1; cyc(3);
    check("R3 hold", scl_pull, 1'b1);
    force_low = 1'b0;
    cyc(1);
    check("R3 release", scl_pull, 1'b0);
    cyc(4);
  endtask

  task automatic t_hold8;
    hold8_en = 1'b1;
    pulse_fall(4'd8);
    check("R4 hold8", scl_pull, 1'b1);
    check("R8 own hold stall", gen_stall, 1'b1);
    hold8_en = 1'b0;
    cyc(2);
    check("R5 release", scl_pull, 1'b0);
    cyc(4);
    check("R8 stall clear", gen_stall, 1'b0);
  endtask

  task automatic t_other_idx;
    hold8_en = 1'b1;
    hold9_en = 1'b1;
    delayed_clk = 1'b1;
    pulse_fall(4'd7);
    check("R10 idx7", scl_pull, 1'b0);
    pulse_fall(4'd3);
    check("R10 idx3", scl_pull, 1'b0);
    hold8_en = 1'b0; hold9_en = 1'b0; delayed_clk = 1'b0;
    cyc(2);
  endtask

  task automatic t_hold9;
    hold9_en = 1'b1;
    delayed_clk = 1'b0;
    pulse_fall(4'd9);
    check("R7 ignored", scl_pull, 1'b0);
    delayed_clk = 1'b1;
    pulse_fall(4'd9);
    check("R6 hold9", scl_pull, 1'b1);
    hold9_en = 1'b0;
    cyc(2);
    check("R6 release", scl_pull, 1'b0);
    delayed_clk = 1'b0;
    cyc(4);
  endtask

  task automatic t_stretch;
    gen_scl = 1'b1;
    ext_low = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 not early", gen_stall, 1'b0);
    cyc(1);
    check("R9 on time", gen_stall, 1'b1);
    cyc(3);
    check("R8 external", gen_stall, 1'b1);
    check("R8 pad released", scl_pull, 1'b0);
    ext_low = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 clear not early", gen_stall, 1'b1);
    cyc(1);
    check("R8 clear", gen_stall, 1'b0);
  endtask

  initial begin
    t_reset();
    t_gen_clock();
    t_force();
    t_hold8();
    t_other_idx();
    t_hold9();
    t_stretch();
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule